// File: doc/BRIEF.md
# Byte-Parity Check and Generate Port

This block is one 36-bit data port of a bidirectional FIFO, seen from the parity point of view. The word is four 9-bit bytes. Byte i occupies bits 9i+8 down to 9i, and bit 9i+8 is that byte's parity bit. A parity flag (`perr_n`, active low) watches the input bus at all times. It drops when any byte enabled in `byte_mask` breaks the parity sense chosen by `odd_sel`. All nine bits of the byte are counted. `odd_sel` high means odd parity: a good byte has an odd number of ones.

Writes store every bit as applied. They go either into a small first-in first-out store, which stands in for FIFO memory, or into a single mailbox register. Reads load a registered output word. When `gen_par` is high at a read edge, each outgoing parity bit is replaced by one computed from the byte's low eight bits. Stored contents are never changed by this. One parity tree per byte serves two jobs. It checks the input bus, and during a mailbox read with generation it computes the mailbox parity. While the trees are doing that second job, the flag is held high. The FIFO read path has its own generator trees, placed between the store and the output register.

An access is the cycle where `cs_n` is low and `en` is high. There is no back-pressure: every access completes at the rising edge that ends its cycle. The caller keeps the store within its depth.

Top module: `bpar_port`

## Requirements
- R1: With all four `byte_mask` bits set, `perr_n` is low exactly when some byte's nine bits hold an even count of ones with `odd_sel`=1, or an odd count with `odd_sel`=0.
- R2: `byte_mask` bit i enables checking of byte i only; a byte whose mask bit is 0 never pulls `perr_n` low, and a zero mask keeps it high.
- R3: `perr_n` is combinational from `din`, `byte_mask` and `odd_sel`, and follows them in idle, write and FIFO-read cycles without waiting for a clock edge.
- R4: During a mailbox read with generation (`cs_n`=0, `en`=1, `wr_sel`=0, `mbx_sel`=1, `gen_par`=1), `perr_n` is high whatever is on `din`. A mailbox read without generation still checks `din`.
- R5: A write stores all 36 bits exactly as applied, including wrong parity bits, whatever `gen_par` is. A read with `gen_par`=0 returns them bit for bit.
- R6: On a read with `gen_par`=1, output bit 9i+8 is the XOR of bits 9i+7..9i XORed with `odd_sel`, and bits 9i+7..9i are passed unchanged. This holds for mailbox and FIFO reads.
- R7: Reading the mailbox, with or without generation, leaves its contents unchanged.
- R8: `dout` resets to zero, loads only at the rising edge that ends a read access, and is visible one edge later. It holds through idle and write cycles.
- R9: FIFO reads return words in write order across `DEPTH` entries. `gen_par` and `odd_sel` act only at the loading edge, and later changes leave `dout` as loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| en | input | 1 | Access enable |
| wr_sel | input | 1 | 1 = write, 0 = read |
| mbx_sel | input | 1 | 1 = mailbox register, 0 = FIFO store |
| gen_par | input | 1 | Replace parity bits on reads |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| byte_mask | input | 4 | Per-byte check enable |
| din | input | 36 | Input bus |
| dout | output | 36 | Output register |
| perr_n | output | 1 | Active-low parity error flag |

## Verification
The bench uses the defaults NBYTES=4, DBITS=8, DEPTH=4. With 9-bit bytes, every byte sees all 512 values, each under both parity senses and all 16 mask settings, and the bench compares the flag against a count of ones made in the bench. With a depth of four, full store passes with write-order checks fit in a short run. The same small size also lets mailbox and FIFO reads alternate generation on and off and switch the parity sense from word to word.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE    = 3'd0,
    ACC_WR_FIFO = 3'd1,
    ACC_WR_MBX  = 3'd2,
    ACC_RD_FIFO = 3'd3,
    ACC_RD_MBX  = 3'd4
  } acc_t;

endpackage

// File: rtl/bpar_decode.sv
module bpar_decode
  import bpar_pkg::*;
(
  input  logic cs_n,
  input  logic en,
  input  logic wr_sel,
  input  logic mbx_sel,
  output acc_t acc
);

  always_comb begin
    acc = ACC_IDLE;
    if (!cs_n && en) begin
      if (wr_sel) acc = mbx_sel ? ACC_WR_MBX : ACC_WR_FIFO;
      else        acc = mbx_sel ? ACC_RD_MBX : ACC_RD_FIFO;
    end
  end

endmodule

// File: rtl/bpar_tree.sv
// One byte's parity tree: produces the parity bit that the low data bits
// need for the chosen sense. A check compares it with the received bit.
module bpar_tree #(
  parameter int DBITS = 8
) (
  input  logic [DBITS-1:0] data_in,
  input  logic             odd_sel,
  output logic             par_bit
);

  assign par_bit = (^data_in) ^ odd_sel;

endmodule

// File: rtl/bpar_store.sv
module bpar_store #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wdata;
  end

  assign rdata = mem[rptr];

endmodule

// File: rtl/bpar_port.sv
module bpar_port
  import bpar_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int DBITS  = 8,
  parameter int DEPTH  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cs_n,
  input  logic                            en,
  input  logic                            wr_sel,
  input  logic                            mbx_sel,
  input  logic                            gen_par,
  input  logic                            odd_sel,
  input  logic [NBYTES-1:0]               byte_mask,
  input  logic [NBYTES*(DBITS+1)-1:0]     din,
  output logic [NBYTES*(DBITS+1)-1:0]     dout,
  output logic                            perr_n
);

  localparam int BW = DBITS + 1;
  localparam int W  = NBYTES * BW;

  acc_t            acc;
  logic            mbx_gen;
  logic [W-1:0]    mbox_q;
  logic [W-1:0]    tree_src;
  logic [W-1:0]    mbx_word;
  logic [W-1:0]    st_word;
  logic [W-1:0]    fifo_word;
  logic [NBYTES-1:0] chk_bit;
  logic [NBYTES-1:0] fifo_bit;
  logic [NBYTES-1:0] bad;

  bpar_decode u_dec (
    .cs_n    (cs_n),
    .en      (en),
    .wr_sel  (wr_sel),
    .mbx_sel (mbx_sel),
    .acc     (acc)
  );

  // Shared trees switch to the mailbox while it is read with generation.
  assign mbx_gen  = (acc == ACC_RD_MBX) && gen_par;
  assign tree_src = mbx_gen ? mbox_q : din;

  bpar_store #(.WIDTH(W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (acc == ACC_WR_FIFO),
    .rd_en (acc == ACC_RD_FIFO),
    .wdata (din),
    .rdata (st_word)
  );

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    bpar_tree #(.DBITS(DBITS)) u_shared (
      .data_in (tree_src[b*BW +: DBITS]),
      .odd_sel (odd_sel),
      .par_bit (chk_bit[b])
    );

    bpar_tree #(.DBITS(DBITS)) u_fifo_gen (
      .data_in (st_word[b*BW +: DBITS]),
      .odd_sel (odd_sel),
      .par_bit (fifo_bit[b])
    );

    assign bad[b] = chk_bit[b] ^ din[b*BW + DBITS];

    assign mbx_word[b*BW +: BW] =
      {gen_par ? chk_bit[b] : mbox_q[b*BW + DBITS], mbox_q[b*BW +: DBITS]};
    assign fifo_word[b*BW +: BW] =
      {gen_par ? fifo_bit[b] : st_word[b*BW + DBITS], st_word[b*BW +: DBITS]};
  end

  assign perr_n = mbx_gen | ~(|(bad & byte_mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbox_q <= '0;
      dout   <= '0;
    end else begin
      if (acc == ACC_WR_MBX) mbox_q <= din;
      if (acc == ACC_RD_MBX)       dout <= mbx_word;
      else if (acc == ACC_RD_FIFO) dout <= fifo_word;
    end
  end

endmodule

// File: rtl/bpar_port_chk.sv
module bpar_port_chk #(
  parameter int NBYTES = 4,
  parameter int DBITS  = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cs_n,
  input logic                        en,
  input logic                        wr_sel,
  input logic                        mbx_sel,
  input logic                        gen_par,
  input logic                        odd_sel,
  input logic [NBYTES-1:0]           byte_mask,
  input logic [NBYTES*(DBITS+1)-1:0] din,
  input logic [NBYTES*(DBITS+1)-1:0] dout,
  input logic                        perr_n
);

  localparam int BW = DBITS + 1;
  localparam int W  = NBYTES * BW;

  logic         rd;
  logic [W-1:0] shadow;

  assign rd = !cs_n && en && !wr_sel;

  function automatic logic par_ok(input logic [W-1:0] w, input logic odd);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < NBYTES; b++) begin
      if ((^w[b*BW +: BW]) != odd) ok = 1'b0;
    end
    return ok;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) shadow <= '0;
    else if (!cs_n && en && wr_sel && mbx_sel) shadow <= din;
  end

  // R4
  mbx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && mbx_sel && gen_par) |-> perr_n);

  // R7
  mbx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && mbx_sel && !gen_par) |=> (dout == $past(shadow)));

  // R6
  gen_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && gen_par) |=> par_ok(dout, $past(odd_sel)));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(dout));

  // R2
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_mask == '0) |-> perr_n);

endmodule

bind bpar_port bpar_port_chk #(.NBYTES(NBYTES), .DBITS(DBITS)) u_port_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .en        (en),
  .wr_sel    (wr_sel),
  .mbx_sel   (mbx_sel),
  .gen_par   (gen_par),
  .odd_sel   (odd_sel),
  .byte_mask (byte_mask),
  .din       (din),
  .dout      (dout),
  .perr_n    (perr_n)
);

// File: tb/test_bpar_port.sv
`timescale 1ns/1ps
module test_bpar_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, en = 1'b0, wr_sel = 1'b0, mbx_sel = 1'b0;
  logic        gen_par = 1'b0, odd_sel = 1'b0;
  logic [3:0]  byte_mask = 4'h0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        perr_n;

  int n_chk = 0;
  int n_fail = 0;
  logic        flag_seen;
  logic [35:0] words [4];
  logic [35:0] held;

  always #4 clk = ~clk;

  bpar_port i_bpar_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .en(en), .wr_sel(wr_sel),
    .mbx_sel(mbx_sel), .gen_par(gen_par), .odd_sel(odd_sel),
    .byte_mask(byte_mask), .din(din), .dout(dout), .perr_n(perr_n)
  );

  function automatic logic [35:0] genw(input logic [35:0] w, input logic odd);
    logic [35:0] r;
    r = w;
    for (int b = 0; b < 4; b++) r[b*9+8] = (^w[b*9 +: 8]) ^ odd;
    return r;
  endfunction

  function automatic logic flag_exp(input logic [35:0] w, input logic [3:0] m,
                                    input logic odd);
    logic err;
    err = 1'b0;
    for (int b = 0; b < 4; b++) begin
      if (m[b] && (($countones(w[b*9 +: 9]) % 2) != int'(odd))) err = 1'b1;
    end
    return !err;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic mb, input logic g, input logic o,
                        input logic [3:0] m, input logic [35:0] d);
    @(negedge clk);
    cs_n = 1'b0; en = 1'b1; wr_sel = w; mbx_sel = mb; gen_par = g; odd_sel = o;
    byte_mask = m; din = d;
    #1 flag_seen = perr_n;
    @(posedge clk);
    #1;
    cs_n = 1'b1; en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    cs_n = 1'b1; en = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R8 reset", dout, 36'h0);
    @(negedge clk) rst_n = 1'b1;

    // Flag sweep: every byte takes all 512 values, both senses, all masks.
    for (int v = 0; v < 512; v++) begin
      for (int o = 0; o < 2; o++) begin
        for (int m = 0; m < 16; m++) begin
          logic [8:0] x;
          x = 9'(v);
          din = {{x[0], x[8:1]}, ~x, x ^ 9'h155, x};
          odd_sel = o[0];
          byte_mask = 4'(m);
          #1;
          if (m == 15) chk("R1 flag", {35'h0, perr_n}, {35'h0, flag_exp(din, 4'hF, o[0])});
          else         chk("R2 masked flag", {35'h0, perr_n}, {35'h0, flag_exp(din, 4'(m), o[0])});
        end
      end
    end

    // FIFO: bad parity written with generation on, read back raw.
    for (int k = 0; k < 4; k++) words[k] = 36'h9A5C3E1F7 ^ (36'h123456789 * (k + 1));
    for (int k = 0; k < 4; k++) begin
      access(1'b1, 1'b0, 1'b1, k[0], 4'hF, words[k]);
      chk("R3 flag on write", {35'h0, flag_seen}, {35'h0, flag_exp(words[k], 4'hF, k[0])});
    end
    held = dout;
    chk("R8 hold over writes", dout, held);
    for (int k = 0; k < 4; k++) begin
      access(1'b0, 1'b0, 1'b0, 1'b1, 4'hF, 36'hFFFFFFFFF);
      chk("R5 raw read", dout, words[k]);
      chk("R3 flag on read", {35'h0, flag_seen}, {35'h0, flag_exp(36'hFFFFFFFFF, 4'hF, 1'b1)});
    end
    held = dout;
    idle();
    chk("R8 hold idle", dout, held);

    // FIFO with generation, sense alternating per word.
    for (int k = 0; k < 4; k++) access(1'b1, 1'b0, 1'b0, 1'b0, 4'h0, ~words[k]);
    for (int k = 0; k < 4; k++) begin
      access(1'b0, 1'b0, 1'b1, k[0], 4'hF, 36'h0);
      chk("R6 fifo gen", dout, genw(~words[k], k[0]));
      @(negedge clk) odd_sel = ~k[0]; gen_par = 1'b0;
      #1 chk("R9 sampled at edge", dout, genw(~words[k], k[0]));
    end

    // Mailbox.
    access(1'b1, 1'b1, 1'b0, 1'b0, 4'hF, 36'h987654321);
    access(1'b0, 1'b1, 1'b1, 1'b1, 4'hF, 36'h100000000);
    chk("R4 flag forced high", {35'h0, flag_seen}, 36'h1);
    chk("R6 mbx gen odd", dout, genw(36'h987654321, 1'b1));
    access(1'b0, 1'b1, 1'b1, 1'b0, 4'hF, 36'h100000000);
    chk("R6 mbx gen even", dout, genw(36'h987654321, 1'b0));
    access(1'b0, 1'b1, 1'b0, 1'b1, 4'hF, 36'h100000000);
    chk("R4 check without gen", {35'h0, flag_seen}, {35'h0, flag_exp(36'h100000000, 4'hF, 1'b1)});
    chk("R7 mailbox unchanged", dout, 36'h987654321);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule